// File: doc/BRIEF.md
# Status Register and Write-Protect Arbiter

This block keeps the status register of a serial nonvolatile memory and decides, for each write that the serial engine wants to perform, whether it may go ahead. The serial engine decodes the command stream and passes single-cycle event pulses to this block. These events mark the start of a transaction (chip select falling), set or clear of the write-enable latch, a status write together with its data byte, and the end of a write transaction (chip select rising). The block also receives the active-low write-protect pin and the 15-bit target address of each memory byte.

The block returns the status byte for status reads and two grant signals. The memory grant covers the byte at the presented address. The status grant covers a status write in the current transaction. Three layers of protection apply. The write-enable latch gates every write. A two-bit block code protects an upper part of the array. The hardware pin guards the status register only, and only when the pin-enable bit is set. The write-enable latch and the pin level are both captured when chip select falls, so each grant stays fixed for the whole transaction. The nonvolatile protect bits are plain registers that reset to a parameter value.

Top module: `wprot_ctrl`

## Requirements
- R1: The status byte reads bit 7 = pin-enable, bits 3:2 = block code, bit 1 = write-enable latch (WEL). Bits 0, 4, 5 and 6 always read 0.
- R2: After reset, WEL is 0 and the pin-enable and block-code bits take their values from the SR_INIT parameter. With the default of 0 the status byte is 0x00 and both grants are 0.
- R3: A set pulse sets WEL one cycle later, and a clear pulse clears it. If a set pulse arrives in the same cycle as a clear pulse or a write-end pulse, WEL is cleared.
- R4: A write-end pulse clears WEL. This holds whether the transaction wrote memory or the status register.
- R5: A granted status write loads bit 7 into pin-enable and bits 3:2 into the block code. Data bit 1 has no effect on WEL, and the other data bits are discarded.
- R6: The block code selects the protected range. 00 protects nothing, 01 protects 0x6000–0x7FFF, 10 protects 0x4000–0x7FFF, and 11 protects the whole array.
- R7: If WEL was 0 when chip select fell, neither the memory grant nor the status grant is given for that transaction.
- R8: If WEL was 1 when chip select fell, the status grant is refused only when pin-enable is 1 and the pin was low. Otherwise it is given.
- R9: The pin level is captured at the chip-select falling event. A change of the pin during a transaction has no effect until the next falling event.
- R10: The memory grant is 1 only when WEL was 1 at the start of the transaction and the address lies outside the protected range. It holds for every byte of the transaction, and a WEL set that arrives after the start does not open it.
- R11: A refused status write leaves pin-enable and the block code unchanged. The following write-end pulse still clears WEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_cs_fall | input | 1 | Pulse: a transaction starts (chip select fell) |
| ev_set_wel | input | 1 | Pulse: set-enable command |
| ev_clr_wel | input | 1 | Pulse: clear-enable command |
| ev_sr_wr | input | 1 | Pulse: status write with data on sr_wdata |
| sr_wdata | input | 8 | Data byte of the status write |
| ev_wr_end | input | 1 | Pulse: a write transaction ended (chip select rose) |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| mem_addr | input | 15 | Address of the memory byte being written |
| status_byte | output | 8 | Status register as read back |
| mem_wr_ok | output | 1 | Memory byte write granted |
| sr_wr_ok | output | 1 | Status write granted |

## Verification
The bench checks each range edge: 0x5FFF against 0x6000, and 0x3FFF against 0x4000. A decoder that is off by one range or misreads the code shifts one of these grants. It moves the pin during an open transaction in both directions. A design that samples the pin live would let a write through or block one it should not. It sets WEL after a transaction has already started. A design that reads the live latch would grant a memory write the command stream never enabled. It also writes status data with bit 1 at both values and fires a set pulse together with a write-end pulse. A wrong priority or a writable latch bit leaves WEL at the wrong value.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    // register image of the status bits that can hold state
    typedef struct packed {
        logic       pin_en;   // hardware pin guards status writes
        logic [1:0] blk;      // block protect code
        logic       wel;      // write-enable latch
    } sr_state_t;

    // values captured when a transaction starts
    typedef struct packed {
        logic wp_n;           // pin level at the falling event
        logic wel;            // latch value at the falling event
    } op_ctx_t;

    localparam int unsigned SR_PIN_EN_BIT = 7;
    localparam int unsigned SR_BLK_HI_BIT = 3;
    localparam int unsigned SR_BLK_LO_BIT = 2;
    localparam int unsigned SR_WEL_BIT    = 1;

    function automatic logic [7:0] sr_pack(input sr_state_t s);
        logic [7:0] b;
        b                = 8'h00;
        b[SR_PIN_EN_BIT] = s.pin_en;
        b[SR_BLK_HI_BIT] = s.blk[1];
        b[SR_BLK_LO_BIT] = s.blk[0];
        b[SR_WEL_BIT]    = s.wel;
        return b;
    endfunction

endpackage

// File: rtl/wprot_range.sv
module wprot_range #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic [1:0]        blk,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned TOP = ADDR_W - 1;

    logic in_quarter;
    logic in_half;

    assign in_half    = addr[TOP];
    assign in_quarter = addr[TOP] & addr[TOP-1];

    always_comb begin
        unique case (blk)
            2'b00:   hit = 1'b0;
            2'b01:   hit = in_quarter;
            2'b10:   hit = in_half;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wprot_opctx.sv
module wprot_opctx
    import wprot_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_fall,
    input  logic    wr_end,
    input  logic    wp_n,
    input  logic    wel_now,
    output op_ctx_t ctx
);
    op_ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (cs_fall) begin
            ctx_d.wp_n = wp_n;
            ctx_d.wel  = wel_now;
        end else if (wr_end) begin
            ctx_d.wel  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{wp_n: 1'b1, wel: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign ctx = ctx_q;
endmodule

// File: rtl/wprot_status.sv
module wprot_status
    import wprot_pkg::*;
#(
    parameter logic [7:0] SR_INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       wr_end,
    input  logic       sr_wr,
    input  logic [7:0] sr_wdata,
    input  logic       sr_grant,
    output sr_state_t  st
);
    localparam sr_state_t ST_RESET = '{
        pin_en: SR_INIT[SR_PIN_EN_BIT],
        blk:    SR_INIT[SR_BLK_HI_BIT:SR_BLK_LO_BIT],
        wel:    1'b0
    };

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sr_wr && sr_grant) begin
            st_d.pin_en = sr_wdata[SR_PIN_EN_BIT];
            st_d.blk    = sr_wdata[SR_BLK_HI_BIT:SR_BLK_LO_BIT];
        end
        if (set_wel) begin
            st_d.wel = 1'b1;
        end
        if (clr_wel || wr_end) begin
            st_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int unsigned ADDR_W  = 15,
    parameter logic [7:0]  SR_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_cs_fall,
    input  logic              ev_set_wel,
    input  logic              ev_clr_wel,
    input  logic              ev_sr_wr,
    input  logic [7:0]        sr_wdata,
    input  logic              ev_wr_end,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        status_byte,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok
);
    sr_state_t st;
    op_ctx_t   ctx;
    logic      blk_hit;
    logic      pin_lock;

    wprot_status #(.SR_INIT(SR_INIT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wel  (ev_set_wel),
        .clr_wel  (ev_clr_wel),
        .wr_end   (ev_wr_end),
        .sr_wr    (ev_sr_wr),
        .sr_wdata (sr_wdata),
        .sr_grant (sr_wr_ok),
        .st       (st)
    );

    wprot_opctx u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_fall (ev_cs_fall),
        .wr_end  (ev_wr_end),
        .wp_n    (wp_n),
        .wel_now (st.wel),
        .ctx     (ctx)
    );

    wprot_range #(.ADDR_W(ADDR_W)) u_range (
        .blk  (st.blk),
        .addr (mem_addr),
        .hit  (blk_hit)
    );

    assign pin_lock    = st.pin_en & ~ctx.wp_n;
    assign sr_wr_ok    = ctx.wel & ~pin_lock;
    assign mem_wr_ok   = ctx.wel & ~blk_hit;
    assign status_byte = sr_pack(st);
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_clr_wel,
    input logic              ev_sr_wr,
    input logic              ev_wr_end,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        status_byte,
    input logic              mem_wr_ok,
    input logic              sr_wr_ok
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte & 8'h71) == 8'h00);

    // R4
    wel_drop_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr_end |=> !status_byte[1]);

    // R3
    wel_drop_on_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clr_wel |=> !status_byte[1]);

    // R11
    refused_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sr_wr && !sr_wr_ok) |=> $stable({status_byte[7], status_byte[3:2]}));

    // R6
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_wr_ok);

    // R6
    upper_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b01 && mem_addr[ADDR_W-1:ADDR_W-2] == 2'b11) |-> !mem_wr_ok);
endmodule

bind wprot_ctrl wprot_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_clr_wel  (ev_clr_wel),
    .ev_sr_wr    (ev_sr_wr),
    .ev_wr_end   (ev_wr_end),
    .mem_addr    (mem_addr),
    .status_byte (status_byte),
    .mem_wr_ok   (mem_wr_ok),
    .sr_wr_ok    (sr_wr_ok)
);

// File: tb/wprot_ctrl_test.sv
`timescale 1ns/1ps
module wprot_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_cs_fall = 1'b0, ev_set_wel = 1'b0, ev_clr_wel = 1'b0;
    logic        ev_sr_wr = 1'b0, ev_wr_end = 1'b0, wp_n = 1'b1;
    logic [7:0]  sr_wdata = 8'h00;
    logic [14:0] mem_addr = 15'h0;
    logic [7:0]  status_byte;
    logic        mem_wr_ok, sr_wr_ok;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    wprot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ev_cs_fall(ev_cs_fall), .ev_set_wel(ev_set_wel),
        .ev_clr_wel(ev_clr_wel), .ev_sr_wr(ev_sr_wr), .sr_wdata(sr_wdata),
        .ev_wr_end(ev_wr_end), .wp_n(wp_n), .mem_addr(mem_addr),
        .status_byte(status_byte), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    task automatic tick; @(negedge clk); endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h, want 0x%02h", req, act, exp);
        end
    endtask

    task automatic cs_fall; ev_cs_fall = 1'b1; tick; ev_cs_fall = 1'b0; endtask
    task automatic set_wel; ev_set_wel = 1'b1; tick; ev_set_wel = 1'b0; endtask
    task automatic clr_wel; ev_clr_wel = 1'b1; tick; ev_clr_wel = 1'b0; endtask
    task automatic wr_end;  ev_wr_end  = 1'b1; tick; ev_wr_end  = 1'b0; endtask
    task automatic sr_write(input logic [7:0] d);
        sr_wdata = d; ev_sr_wr = 1'b1; tick; ev_sr_wr = 1'b0;
    endtask
    task automatic wren_op; cs_fall(); set_wel(); endtask
    task automatic probe(input string req, input logic [14:0] a, input logic exp);
        mem_addr = a; #1;
        chk(req, {7'd0, mem_wr_ok}, {7'd0, exp});
    endtask
    task automatic load_sr(input logic [7:0] d);
        wp_n = 1'b1; wren_op(); cs_fall(); sr_write(d); wr_end();
    endtask

    task automatic t_reset;
        chk("R2 status", status_byte, 8'h00);
        chk("R2 sr grant", {7'd0, sr_wr_ok}, 8'h00);
        probe("R2 mem grant", 15'h0000, 1'b0);
    endtask

    task automatic t_latch;
        wren_op();
        chk("R3 set", status_byte, 8'h02);
        cs_fall(); clr_wel();
        chk("R3 clear", status_byte, 8'h00);
        set_wel();
        ev_set_wel = 1'b1; ev_wr_end = 1'b1; tick; ev_set_wel = 1'b0; ev_wr_end = 1'b0;
        chk("R3 set vs end", status_byte, 8'h00);
        set_wel();
        ev_set_wel = 1'b1; ev_clr_wel = 1'b1; tick; ev_set_wel = 1'b0; ev_clr_wel = 1'b0;
        chk("R3 set vs clear", status_byte, 8'h00);
    endtask

    task automatic t_status_write;
        wren_op(); cs_fall();
        chk("R8 grant", {7'd0, sr_wr_ok}, 8'h01);
        sr_write(8'hFF);
        chk("R5 load", status_byte, 8'h8E);
        chk("R1 layout", status_byte & 8'h71, 8'h00);
        wr_end();
        chk("R4 end after status write", status_byte, 8'h8C);
    endtask

    task automatic t_pin_lock;
        wp_n = 1'b1; wren_op();
        wp_n = 1'b0; cs_fall();
        chk("R8 refused", {7'd0, sr_wr_ok}, 8'h00);
        wp_n = 1'b1; tick;
        chk("R9 late pin rise", {7'd0, sr_wr_ok}, 8'h00);
        sr_write(8'h00);
        chk("R11 bits kept", status_byte, 8'h8E);
        wr_end();
        chk("R11 wel cleared", status_byte, 8'h8C);
        wren_op(); cs_fall();
        wp_n = 1'b0; tick;
        chk("R9 late pin fall", {7'd0, sr_wr_ok}, 8'h01);
        sr_write(8'h00);
        chk("R5 bit1 zero keeps wel", status_byte, 8'h02);
        wr_end();
        chk("R4 end", status_byte, 8'h00);
        wren_op(); cs_fall();
        chk("R8 pin ignored when disabled", {7'd0, sr_wr_ok}, 8'h01);
        sr_write(8'h84); wr_end();
        chk("R5 load 0x84", status_byte, 8'h84);
    endtask

    task automatic t_ranges;
        wp_n = 1'b1; wren_op(); cs_fall();
        probe("R6 code01 below", 15'h5FFF, 1'b1);
        probe("R10 code01 edge", 15'h6000, 1'b0);
        probe("R6 code01 top", 15'h7FFF, 1'b0);
        probe("R10 later byte", 15'h0001, 1'b1);
        wr_end();
        cs_fall();
        chk("R7 no status grant", {7'd0, sr_wr_ok}, 8'h00);
        probe("R7 no mem grant", 15'h0000, 1'b0);
        set_wel();
        probe("R10 late set", 15'h0000, 1'b0);
        wr_end();
        load_sr(8'h08);
        chk("R5 code10 loaded", status_byte, 8'h08);
        wren_op(); cs_fall();
        probe("R6 code10 below", 15'h3FFF, 1'b1);
        probe("R6 code10 edge", 15'h4000, 1'b0);
        wr_end();
        load_sr(8'h0C);
        wren_op(); cs_fall();
        probe("R6 code11 zero", 15'h0000, 1'b0);
        wr_end();
        load_sr(8'h00);
        wren_op(); cs_fall();
        probe("R6 code00 top", 15'h7FFF, 1'b1);
        wr_end();
        chk("R4 end after memory write", status_byte, 8'h00);
    endtask

    initial begin
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        t_reset();
        t_latch();
        t_status_write();
        t_pin_lock();
        t_ranges();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule